// File: doc/BRIEF.md
# Memory-Mapped 32-Pin GPIO Port Controller

This block is the register and control core of a 32-pin general-purpose I/O port. It sits on a simple 32-bit register bus that has a write strobe, a read strobe and a byte address. Each pin has one bit in every register. A direction register selects input or output for each pin. Setting a bit makes that pin an input. A data-out register holds the values driven onto output pins. Software can also change data-out without a read-modify-write by writing a mask to a separate set address or clear address.

Pad levels pass through a two-flop synchronizer. The synchronized value can be read back as data-in, and it also goes out on `sync_in` to an external event detector. That detector returns a 32-bit vector of detected events. The block gates those events with a per-pin interrupt enable and latches them into a write-one-to-clear status register. It drives a single registered interrupt line.

A parameter chooses one of two address layouts. In the compact layout, the interrupt enable is a plain read/write register. In the split layout, the enable is changed only through write-one-to-set and write-one-to-clear addresses, and the remaining registers sit 0x100 higher.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, direction reads all ones and `pad_oe` is all zeros. Data-out, interrupt enable and status all read zero, and `irq` is low.
- R2: Direction bit i = 1 makes pin i an input (`pad_oe[i]` = 0), and 0 makes it an output (`pad_oe[i]` = 1). The direction register is read/write at 0x34 (compact layout) or 0x134 (split layout).
- R3: Writing a mask to the set address (0x94 compact, 0x194 split) sets the mask's one-bits in data-out. Its zero-bits leave data-out unchanged.
- R4: Writing a mask to the clear address (0x90 compact, 0x190 split) clears the mask's one-bits in data-out. Its zero-bits leave data-out unchanged.
- R5: Data-out is read/write at 0x3C (compact) or 0x13C (split). `pad_out` shows its value from the clock edge that performs the write.
- R6: `sync_in` equals `pad_in` delayed by two clock edges. Data-in (0x38 compact, 0x138 split) reads `sync_in`. Writes to data-in have no effect.
- R7: A status bit becomes 1 only when its event input is high at a clock edge while its enable bit is 1. Events on disabled pins leave status unchanged.
- R8: Status (0x18 compact, 0x2C split) is write-one-to-clear. If an event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R9: `irq` is a register output. After every clock edge it equals the OR of all status bits.
- R10: In the compact layout, the enable is read/write at 0x1C. In the split layout, a write to 0x34 sets the mask bits and a write to 0x38 clears them. Reads at either address return the enable.
- R11: A read from any address not mapped in the active layout returns zero. A write to such an address changes no register.
- R12: Read data appears on `bus_rdata` at the clock edge where `bus_rd` is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_oe | output | 32 | Per-pin output enable, 1 = drive |
| pad_out | output | 32 | Per-pin output value |
| sync_in | output | 32 | Synchronized pad levels for the event detector |
| evt_in | input | 32 | Detected events, one bit per pin |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
Two things can happen at the same clock edge: a pin's event is latched into status, and software clears that status with a write-one-to-clear acknowledge. The bench sets this up by raising an event on an enabled bit in the same cycle as a status write. That write clears both the event's bit and a second bit that has no new event. It then reads status back. The result passes only if the event's bit stays set, the other bit is cleared, and `irq` stays high. A later plain acknowledge must drop `irq` at the next edge.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

   // Register selected by the address decoder
   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DIR,
      SEL_DIN,
      SEL_DOUT,
      SEL_DSET,
      SEL_DCLR,
      SEL_STS,
      SEL_EN,
      SEL_ENSET,
      SEL_ENCLR
   } reg_sel_e;

   localparam int LAYOUT_COMPACT = 0;
   localparam int LAYOUT_SPLIT   = 1;

   // Offset of the highest register in each layout (sizing check)
   function automatic int unsigned top_offset(input int layout);
      return (layout == LAYOUT_SPLIT) ? 32'h194 : 32'h94;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int LAYOUT = LAYOUT_COMPACT
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int unsigned BANK = (LAYOUT == LAYOUT_SPLIT) ? 32'h100 : 32'h0;
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BANK + 32'h34);
   localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(BANK + 32'h38);
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(BANK + 32'h3C);
   localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(BANK + 32'h90);
   localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(BANK + 32'h94);
   localparam logic [ADDR_W-1:0] A_STS  =
      ADDR_W'((LAYOUT == LAYOUT_SPLIT) ? 32'h2C : 32'h18);
   localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(32'h1C);
   localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(32'h34);
   localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(32'h38);

   if (LAYOUT != LAYOUT_COMPACT && LAYOUT != LAYOUT_SPLIT) begin : g_bad_layout
      $error("gpio_addr_decode: LAYOUT must be 0 or 1");
   end
   if (top_offset(LAYOUT) >= (32'd1 << ADDR_W)) begin : g_bad_addr_w
      $error("gpio_addr_decode: ADDR_W too narrow for the layout");
   end

   if (LAYOUT == LAYOUT_SPLIT) begin : g_split
      always_comb begin
         case (addr)
            A_STS:   sel = SEL_STS;
            A_ENSET: sel = SEL_ENSET;
            A_ENCLR: sel = SEL_ENCLR;
            A_DIR:   sel = SEL_DIR;
            A_DIN:   sel = SEL_DIN;
            A_DOUT:  sel = SEL_DOUT;
            A_DCLR:  sel = SEL_DCLR;
            A_DSET:  sel = SEL_DSET;
            default: sel = SEL_NONE;
         endcase
      end
   end else begin : g_compact
      always_comb begin
         case (addr)
            A_STS:   sel = SEL_STS;
            A_EN:    sel = SEL_EN;
            A_DIR:   sel = SEL_DIR;
            A_DIN:   sel = SEL_DIN;
            A_DOUT:  sel = SEL_DOUT;
            A_DCLR:  sel = SEL_DCLR;
            A_DSET:  sel = SEL_DSET;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
   parameter int W        = 32,
   parameter bit SPLIT_EN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_wr,
   input  logic         en_set,
   input  logic         en_clr,
   input  logic         sts_clr,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] evt,
   output logic [W-1:0] en_q,
   output logic [W-1:0] sts_q,
   output logic         irq_q
);

   logic [W-1:0] en_next;
   logic [W-1:0] sts_next;
   logic [W-1:0] hit;

   if (SPLIT_EN) begin : g_en_split
      always_comb begin
         en_next = en_q;
         if (en_set) en_next = en_next | wmask;
         if (en_clr) en_next = en_next & ~wmask;
      end
   end else begin : g_en_plain
      always_comb begin
         en_next = en_wr ? wmask : en_q;
      end
   end

   assign hit = evt & en_q;

   // Clear first, then OR in new hits: an event wins over its own acknowledge
   always_comb begin
      sts_next = sts_q;
      if (sts_clr) sts_next = sts_next & ~wmask;
      sts_next = sts_next | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sts_q <= '0;
         irq_q <= 1'b0;
      end else begin
         en_q  <= en_next;
         sts_q <= sts_next;
         irq_q <= |sts_next;
      end
   end

   // R7: a newly set status bit needs an enabled event one edge earlier
   a_r7_no_spurious_status: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt & en_q)) == '0));

   // R8: an enabled event always leaves its bit set, even under a clearing write
   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt & en_q) & ~sts_q) == '0));

   // R9: the interrupt line tracks the OR of the status register
   a_r9_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (|sts_q));

endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 9,
   parameter int LAYOUT      = LAYOUT_COMPACT,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  sync_in,
   input  logic [NPINS-1:0]  evt_in,
   output logic              irq
);

   localparam bit SPLIT_EN = (LAYOUT == LAYOUT_SPLIT);

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_port_ctrl: NPINS must be between 1 and DATA_W");
   end

   reg_sel_e          sel;
   logic [NPINS-1:0]  wmask;
   logic [NPINS-1:0]  dir_q;
   logic [NPINS-1:0]  dout_q;
   logic [NPINS-1:0]  en_q;
   logic [NPINS-1:0]  sts_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign wmask = bus_wdata[NPINS-1:0];

   gpio_in_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_in)
   );

   gpio_addr_decode #(
      .ADDR_W (ADDR_W),
      .LAYOUT (LAYOUT)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpio_irq_ctrl #(
      .W        (NPINS),
      .SPLIT_EN (SPLIT_EN)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (bus_wr && sel == SEL_EN),
      .en_set  (bus_wr && sel == SEL_ENSET),
      .en_clr  (bus_wr && sel == SEL_ENCLR),
      .sts_clr (bus_wr && sel == SEL_STS),
      .wmask   (wmask),
      .evt     (evt_in),
      .en_q    (en_q),
      .sts_q   (sts_q),
      .irq_q   (irq)
   );

   // Direction and data-out registers with atomic set / clear aliases
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         dout_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_DIR:  dir_q  <= wmask;
            SEL_DOUT: dout_q <= wmask;
            SEL_DSET: dout_q <= dout_q | wmask;
            SEL_DCLR: dout_q <= dout_q & ~wmask;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_DIR:   rd_mux = DATA_W'(dir_q);
         SEL_DIN:   rd_mux = DATA_W'(sync_in);
         SEL_DOUT:  rd_mux = DATA_W'(dout_q);
         SEL_STS:   rd_mux = DATA_W'(sts_q);
         SEL_EN,
         SEL_ENSET,
         SEL_ENCLR: rd_mux = DATA_W'(en_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;
   assign pad_oe    = ~dir_q;
   assign pad_out   = dout_q;

   // R3: every mask bit written to the set alias is high on the pins afterwards
   a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_DSET) |=>
      ((pad_out & $past(wmask)) == $past(wmask)));

   // R3 and R4: zero mask bits leave the driven value alone
   a_r4_alias_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (sel == SEL_DSET || sel == SEL_DCLR)) |=>
      ((pad_out & ~$past(wmask)) == ($past(pad_out) & ~$past(wmask))));

   // R4: every mask bit written to the clear alias is low afterwards
   a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_DCLR) |=> ((pad_out & $past(wmask)) == '0));

   // R11: reads of unmapped addresses return zero
   a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

   // R11: unmapped writes leave the pin outputs untouched
   a_r11_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

   typedef struct {
      logic [31:0] exp;
      int          dut;
      string       tag;
   } rd_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bwr   [2];
   logic        brd   [2];
   logic [8:0]  baddr [2];
   logic [31:0] bwd   [2];
   logic [31:0] rdat  [2];
   logic [31:0] pin   [2];
   logic [31:0] oe    [2];
   logic [31:0] pout  [2];
   logic [31:0] syn   [2];
   logic [31:0] evt   [2];
   logic        irq   [2];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   rd_item_t scb[$];

   always #10 clk = ~clk;   // 50 MHz

   gpio_port_ctrl #(.LAYOUT(0)) i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bwr[0]), .bus_rd(brd[0]),
      .bus_addr(baddr[0]), .bus_wdata(bwd[0]), .bus_rdata(rdat[0]),
      .pad_in(pin[0]), .pad_oe(oe[0]), .pad_out(pout[0]), .sync_in(syn[0]),
      .evt_in(evt[0]), .irq(irq[0]));

   gpio_port_ctrl #(.LAYOUT(1)) i_gpio_port_ctrl_split (
      .clk(clk), .rst_n(rst_n), .bus_wr(bwr[1]), .bus_rd(brd[1]),
      .bus_addr(baddr[1]), .bus_wdata(bwd[1]), .bus_rdata(rdat[1]),
      .pad_in(pin[1]), .pad_oe(oe[1]), .pad_out(pout[1]), .sync_in(syn[1]),
      .evt_in(evt[1]), .irq(irq[1]));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic wr(input int d, input logic [8:0] a, input logic [31:0] v);
      @(negedge clk);
      bwr[d] = 1'b1; baddr[d] = a; bwd[d] = v;
      @(negedge clk);
      bwr[d] = 1'b0; bwd[d] = '0;
   endtask

   // Driver: issue a read and queue the value the requirements predict
   task automatic rd(input int d, input logic [8:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      @(negedge clk);
      brd[d] = 1'b1; baddr[d] = a;
      it.exp = exp; it.dut = d; it.tag = tag;
      scb.push_back(it);
      @(negedge clk);
      brd[d] = 1'b0;
   endtask

   task automatic ev(input int d, input logic [31:0] m);
      @(negedge clk);
      evt[d] = m;
      @(negedge clk);
      evt[d] = '0;
   endtask

   // Monitor: pop the expected read result once the sampling edge has passed
   initial begin
      forever begin
         @(posedge clk);
         if (brd[0] || brd[1]) begin
            #2;
            if (scb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R12: actual unexpected read expected none");
            end else begin
               rd_item_t it;
               it = scb.pop_front();
               chk(rdat[it.dut], it.exp, it.tag);
            end
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog R12: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int d = 0; d < 2; d++) begin
         bwr[d] = 0; brd[d] = 0; baddr[d] = '0; bwd[d] = '0;
         pin[d] = '0; evt[d] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // ---------------- compact layout ----------------
      @(negedge clk);
      chk(oe[0], 32'h0, "R1 pad_oe after reset");
      chk({31'b0, irq[0]}, 32'h0, "R1 irq after reset");
      rd(0, 9'h034, 32'hFFFF_FFFF, "R1 direction reset");
      rd(0, 9'h03C, 32'h0, "R1 data-out reset");
      rd(0, 9'h01C, 32'h0, "R1 enable reset");
      rd(0, 9'h018, 32'h0, "R1 status reset");

      wr(0, 9'h034, 32'hFFFF_0000);
      chk(oe[0], 32'h0000_FFFF, "R2 pad_oe from direction");
      rd(0, 9'h034, 32'hFFFF_0000, "R2 direction readback");

      wr(0, 9'h03C, 32'h1234_5678);
      chk(pout[0], 32'h1234_5678, "R5 pad_out after write");
      wr(0, 9'h094, 32'h0000_000F);
      chk(pout[0], 32'h1234_567F, "R3 set alias");
      wr(0, 9'h090, 32'h1200_0000);
      chk(pout[0], 32'h0034_567F, "R4 clear alias");
      rd(0, 9'h03C, 32'h0034_567F, "R5 data-out readback");

      @(negedge clk);
      pin[0] = 32'hA5A5_0F0F;
      @(negedge clk);
      chk(syn[0], 32'h0, "R6 sync after one edge");
      @(negedge clk);
      chk(syn[0], 32'hA5A5_0F0F, "R6 sync after two edges");
      rd(0, 9'h038, 32'hA5A5_0F0F, "R6 data-in readback");
      wr(0, 9'h038, 32'h0);
      rd(0, 9'h038, 32'hA5A5_0F0F, "R6 data-in write ignored");

      ev(0, 32'h0000_0008);
      chk({31'b0, irq[0]}, 32'h0, "R7 disabled event no irq");
      rd(0, 9'h018, 32'h0, "R7 disabled event no status");

      wr(0, 9'h01C, 32'h0000_0009);
      rd(0, 9'h01C, 32'h0000_0009, "R10 compact enable readback");
      ev(0, 32'h0000_000F);
      chk({31'b0, irq[0]}, 32'h1, "R9 irq after event");
      rd(0, 9'h018, 32'h0000_0009, "R7 enabled events latched");

      // Same-edge event and acknowledge on bit 0; bit 3 has no new event
      @(negedge clk);
      bwr[0] = 1'b1; baddr[0] = 9'h018; bwd[0] = 32'h0000_0009;
      evt[0] = 32'h0000_0001;
      @(negedge clk);
      bwr[0] = 1'b0; bwd[0] = '0; evt[0] = '0;
      chk({31'b0, irq[0]}, 32'h1, "R8 irq stays with event win");
      rd(0, 9'h018, 32'h0000_0001, "R8 event wins over clear");

      wr(0, 9'h018, 32'h0000_0001);
      chk({31'b0, irq[0]}, 32'h0, "R9 irq drops after ack");
      rd(0, 9'h018, 32'h0, "R8 status cleared");

      rd(0, 9'h020, 32'h0, "R11 unmapped read");
      wr(0, 9'h020, 32'hFFFF_FFFF);
      wr(0, 9'h100, 32'h0);
      chk(pout[0], 32'h0034_567F, "R11 unmapped write pad_out");
      rd(0, 9'h034, 32'hFFFF_0000, "R11 direction untouched");
      rd(0, 9'h01C, 32'h0000_0009, "R11 enable untouched");

      // ---------------- split layout ----------------
      rd(1, 9'h134, 32'hFFFF_FFFF, "R1 split direction reset");
      rd(1, 9'h02C, 32'h0, "R1 split status reset");
      wr(1, 9'h034, 32'h0000_0030);
      wr(1, 9'h034, 32'h0000_000C);
      rd(1, 9'h034, 32'h0000_003C, "R10 enable-set accumulates");
      wr(1, 9'h038, 32'h0000_0014);
      rd(1, 9'h038, 32'h0000_0028, "R10 enable-clear");

      wr(1, 9'h194, 32'h0000_00F0);
      wr(1, 9'h190, 32'h0000_0030);
      chk(pout[1], 32'h0000_00C0, "R3 R4 split aliases");
      rd(1, 9'h13C, 32'h0000_00C0, "R5 split data-out readback");

      ev(1, 32'h0000_00FF);
      chk({31'b0, irq[1]}, 32'h1, "R9 split irq");
      rd(1, 9'h02C, 32'h0000_0028, "R7 split status");

      wr(1, 9'h01C, 32'hFFFF_FFFF);
      rd(1, 9'h034, 32'h0000_0028, "R11 split enable untouched");
      rd(1, 9'h01C, 32'h0, "R11 split unmapped read");
      wr(1, 9'h02C, 32'h0000_0028);
      chk({31'b0, irq[1]}, 32'h0, "R8 split ack drops irq");

      repeat (3) @(negedge clk);
      chk(scb.size(), 32'h0, "R12 all reads returned");
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule